// File: doc/BRIEF.md
# DDR SDRAM Command Controller

This block sits between a single host port and the command side of a four-bank double-data-rate SDRAM. The host offers one read or write request at a time as a flat address that packs bank, row and column, with a direction bit, on a valid/ready handshake. The controller turns each request into the command sequence the memory needs: it opens the row if its bank is closed, closes and reopens it on a row miss, and goes straight to the column command on a row hit. It also brings the memory up after reset, loads the mode register with the chosen burst length, burst ordering and CAS latency, and refreshes all banks at a fixed interval.

The request handshake is the only point where the host can apply back-pressure. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. Until then the host must hold the address, the direction and `req_valid` steady. `req_ready` rises only in the cycle the controller commits the column command. Write data is pulled: while `wd_ready` is high, the host must present one beat (two bytes plus a two-bit mask) on every clock, because the memory cannot pause a burst. Read data is pushed on `rd_valid` and cannot be stalled. For CAS latency 2.5, the read window sits on the CAS latency 2 cycles and `rd_half` tells the physical layer to shift capture by half a clock.

Top module: `ddrc_ctrl`

## Requirements
- R1: While reset is asserted and until start-up has finished, `cmd_o` shows NOP (0) except for the start-up commands, and `init_done` and `req_ready` stay low.
- R2: Start-up begins T_INIT cycles after reset is released. It issues, in this order: PRECHARGE with A10=1, LOAD MODE to bank 1 with address 0, LOAD MODE to bank 0 with A8=1, PRECHARGE with A10=1, AUTO REFRESH, AUTO REFRESH, and LOAD MODE to bank 0 with A8=0. `init_done` then goes high.
- R3: The mode word carries the burst code in A[2:0] (1, 2 or 3 for bursts of 2, 4 or 8 beats, set by `cfg_bl` = 0, 1 or 2), the interleaved flag in A3 (`cfg_ilv`), the latency code in A[6:4] (2, 6 or 3 for CAS latency 2, 2.5 or 3, set by `cfg_cl` = 0, 1 or 2), and the DLL reset flag in A8. All configuration inputs are sampled while reset is held.
- R4: Command codes on `cmd_o` are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5 and LOAD MODE=6. `req_addr` is split into bank [24:23], row [22:10] and column [9:0]. READ and WRITE put the column on A[9:0] with A10=0.
- R5: `wd_ready` is high for exactly BL/2 cycles, starting in the cycle after WRITE appears on `cmd_o`, for every CAS latency.
- R6: `rd_valid` is high for exactly BL/2 cycles, starting 2 cycles after READ for CAS latency 2 or 2.5 and 3 cycles after READ for CAS latency 3. `rd_half` is high only for CAS latency 2.5.
- R7: During the write window, `phy_wdata` and `phy_wmask` follow `wd_data` and `wd_mask`; a mask bit set to 1 blocks its byte. Outside the window, `phy_wmask` is all ones.
- R8: A request that hits the open row of its bank issues only READ or WRITE. A request to a closed bank issues ACTIVATE and then the column command.
- R9: A row miss issues PRECHARGE of that bank (A10=0), then ACTIVATE, then the column command. ACTIVATE to column command is at least tRCD, PRECHARGE to ACTIVATE at least tRP, ACTIVATE to PRECHARGE at least tRAS, and last write beat to PRECHARGE at least tWR.
- R10: Refresh is due every T_REFI cycles after start-up. Once the current burst ends, the controller closes all open banks with PRECHARGE A10=1 and issues AUTO REFRESH. No command follows AUTO REFRESH for tRFC cycles, and `req_ready` stays low during that time.
- R11: READ or WRITE appears on `cmd_o` in the cycle right after the handshake edge, with the bank and column of the accepted request.
- R12: The next command after a READ waits until its read window has closed, and the next command after a WRITE waits until its write window has closed. So `rd_valid` and `wd_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cl | input | 2 | CAS latency select: 0=2, 1=2.5, 2=3 |
| cfg_bl | input | 2 | Burst select: 0=2, 1=4, 2=8 beats |
| cfg_ilv | input | 1 | 1 selects interleaved burst ordering |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | {bank, row, column} |
| wd_ready | output | 1 | Write beat pulled this cycle |
| wd_data | input | 16 | Write beat, two bytes |
| wd_mask | input | 2 | Byte mask, 1 = do not write |
| rd_valid | output | 1 | Read beat valid this cycle |
| rd_data | output | 16 | Read beat to host |
| init_done | output | 1 | Start-up finished |
| cmd_o | output | 3 | Memory command code |
| ba_o | output | 2 | Bank address |
| a_o | output | 13 | Row, column or mode address |
| phy_wdata | output | 16 | Write beat to physical layer |
| phy_wmask | output | 2 | Byte mask to physical layer |
| phy_rdata | input | 16 | Read beat from physical layer |
| rd_half | output | 1 | Half-cycle capture shift (CAS latency 2.5) |

## Verification
Every result is counted from the cycle in which a command becomes visible on `cmd_o`, and that cycle is itself one clock after the edge that accepted the request. The write window is expected one cycle later and lasts BL/2 cycles. The read window is expected two or three cycles later and also lasts BL/2 cycles. The first start-up command is expected exactly T_INIT cycles after reset is released. The bench samples once per cycle on the falling edge, counts cycles from the handshake, and compares each window bit against the cycle number the requirement gives. A command monitor time-stamps every command one moment after the rising edge and checks each bank's ACTIVATE, PRECHARGE and column spacings, the quiet period after AUTO REFRESH and the refresh interval, all against those time stamps.

// File: rtl/ddrc_pkg.sv
package ddrc_pkg;
  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_PRE = 3'd4,
    C_REF = 3'd5,
    C_LMR = 3'd6
  } cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_EMR, S_MRD, S_PRE2, S_REF1, S_REF2, S_MR, S_RUN
  } st_e;
endpackage

// File: rtl/ddrc_bank_timers.sv
module ddrc_bank_timers
  import ddrc_pkg::*;
#(
  parameter int NB    = 4,
  parameter int CW    = 6,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RFC = 10,
  parameter int T_WR  = 2,
  localparam int BW   = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic [BW-1:0] bank,
  input  logic          all_banks,
  input  logic [2:0]    burst_half,
  output logic [NB-1:0] act_ok,
  output logic [NB-1:0] rw_ok,
  output logic [NB-1:0] pre_ok
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] act_c, rw_c, pre_c, wr_load;
    logic          sel;

    assign sel     = (bank == BW'(b));
    assign wr_load = CW'(burst_half) + CW'(T_WR - 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_c <= '0;
        rw_c  <= '0;
        pre_c <= '0;
      end else begin
        // ACTIVATE gate: tRP after precharge, tRFC after refresh
        if (cmd == C_PRE && (sel || all_banks))
          act_c <= CW'(T_RP - 1);
        else if (cmd == C_REF)
          act_c <= CW'(T_RFC - 1);
        else if (act_c != '0)
          act_c <= act_c - 1'b1;

        // column gate: tRCD after activate
        if (cmd == C_ACT && sel)
          rw_c <= CW'(T_RCD - 1);
        else if (rw_c != '0)
          rw_c <= rw_c - 1'b1;

        // precharge gate: tRAS after activate, tWR after last write beat
        if (cmd == C_ACT && sel)
          pre_c <= CW'(T_RAS - 1);
        else if (cmd == C_WR && sel)
          pre_c <= (pre_c > wr_load) ? pre_c - 1'b1 : wr_load;
        else if (pre_c != '0)
          pre_c <= pre_c - 1'b1;
      end
    end

    assign act_ok[b] = (act_c == '0);
    assign rw_ok[b]  = (rw_c == '0);
    assign pre_ok[b] = (pre_c == '0);
  end
endmodule

// File: rtl/ddrc_window.sv
module ddrc_window #(
  parameter int DEPTH = 4,
  parameter int LW    = 3,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] sel,
  input  logic [LW-1:0] len,
  output logic          active
);
  logic [DEPTH-1:0] pipe;
  logic [LW-1:0]    cnt;
  logic             tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], start};
  end

  assign tap = pipe[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (tap)        cnt <= len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = tap || (cnt != '0);
endmodule

// File: rtl/ddrc_refresh_timer.sv
module ddrc_refresh_timer #(
  parameter int T_REFI = 975,
  localparam int RW    = $clog2(T_REFI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic due
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RW'(T_REFI - 1);
      due <= 1'b0;
    end else begin
      if (clr) due <= 1'b0;
      if (en) begin
        if (cnt == '0) begin
          cnt <= RW'(T_REFI - 1);
          due <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ddrc_ctrl.sv
module ddrc_ctrl
  import ddrc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DW     = 16,
  parameter int T_INIT = 200,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 6,
  parameter int T_RFC  = 10,
  parameter int T_WR   = 2,
  parameter int T_MRD  = 2,
  parameter int T_REFI = 975,
  localparam int BW    = $clog2(NB),
  localparam int AW    = BW + ROW_W + COL_W,
  localparam int MW    = DW / 8,
  localparam int GMAX  = (T_INIT > T_RFC) ? T_INIT : T_RFC,
  localparam int GW    = $clog2(GMAX + 16),
  localparam int CW    = $clog2(T_RAS + T_RFC + T_WR + T_RCD + T_RP + 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_cl,
  input  logic [1:0]       cfg_bl,
  input  logic             cfg_ilv,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  output logic             wd_ready,
  input  logic [DW-1:0]    wd_data,
  input  logic [MW-1:0]    wd_mask,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             init_done,
  output logic [2:0]       cmd_o,
  output logic [BW-1:0]    ba_o,
  output logic [ROW_W-1:0] a_o,
  output logic [DW-1:0]    phy_wdata,
  output logic [MW-1:0]    phy_wmask,
  input  logic [DW-1:0]    phy_rdata,
  output logic             rd_half
);
  st_e              st, nxt_st;
  cmd_e             cmd_q, nxt_cmd;
  logic [BW-1:0]    ba_q, nxt_ba;
  logic [ROW_W-1:0] a_q, nxt_a;
  logic [GW-1:0]    gap_q, nxt_gap;
  logic [1:0]       cl_q, bl_q;
  logic             ilv_q;
  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];
  logic [NB-1:0]    act_ok, rw_ok, pre_ok;
  logic             ref_due;

  // configuration decode
  logic [2:0] half_len, bl_code, cl_code;
  logic [1:0] cl_int, cl_ceil;
  logic [3:0] rd_gap;

  always_comb begin
    unique case (bl_q)
      2'd0:    begin half_len = 3'd1; bl_code = 3'd1; end
      2'd1:    begin half_len = 3'd2; bl_code = 3'd2; end
      default: begin half_len = 3'd4; bl_code = 3'd3; end
    endcase
    unique case (cl_q)
      2'd0:    begin cl_code = 3'd2; cl_int = 2'd2; cl_ceil = 2'd2; end
      2'd1:    begin cl_code = 3'd6; cl_int = 2'd2; cl_ceil = 2'd3; end
      default: begin cl_code = 3'd3; cl_int = 2'd3; cl_ceil = 2'd3; end
    endcase
    rd_gap = 4'(cl_ceil) + 4'(half_len) - 4'd1;
  end

  function automatic logic [ROW_W-1:0] mode_word(input logic dll_rst);
    logic [ROW_W-1:0] w;
    w      = '0;
    w[2:0] = bl_code;
    w[3]   = ilv_q;
    w[6:4] = cl_code;
    w[8]   = dll_rst;
    return w;
  endfunction

  // request decode
  logic [BW-1:0]    rq_bank;
  logic [ROW_W-1:0] rq_row;
  logic [COL_W-1:0] rq_col;
  assign rq_bank = req_addr[AW-1 -: BW];
  assign rq_row  = req_addr[COL_W +: ROW_W];
  assign rq_col  = req_addr[COL_W-1:0];

  // next-command selection
  always_comb begin
    nxt_st    = st;
    nxt_cmd   = C_NOP;
    nxt_ba    = '0;
    nxt_a     = '0;
    nxt_gap   = (gap_q != '0) ? gap_q - 1'b1 : '0;
    req_ready = 1'b0;
    if (gap_q == '0) begin
      unique case (st)
        S_PWR: begin
          nxt_cmd = C_PRE; nxt_a[10] = 1'b1;
          nxt_gap = GW'(T_RP - 1); nxt_st = S_EMR;
        end
        S_EMR: begin
          nxt_cmd = C_LMR; nxt_ba = BW'(1);
          nxt_gap = GW'(T_MRD - 1); nxt_st = S_MRD;
        end
        S_MRD: begin
          nxt_cmd = C_LMR; nxt_a = mode_word(1'b1);
          nxt_gap = GW'(T_MRD - 1); nxt_st = S_PRE2;
        end
        S_PRE2: begin
          nxt_cmd = C_PRE; nxt_a[10] = 1'b1;
          nxt_gap = GW'(T_RP - 1); nxt_st = S_REF1;
        end
        S_REF1: begin
          nxt_cmd = C_REF; nxt_gap = GW'(T_RFC - 1); nxt_st = S_REF2;
        end
        S_REF2: begin
          nxt_cmd = C_REF; nxt_gap = GW'(T_RFC - 1); nxt_st = S_MR;
        end
        S_MR: begin
          nxt_cmd = C_LMR; nxt_a = mode_word(1'b0);
          nxt_gap = GW'(T_MRD - 1); nxt_st = S_RUN;
        end
        default: begin
          if (ref_due) begin
            if (|open_q) begin
              if (&pre_ok) begin
                nxt_cmd = C_PRE; nxt_a[10] = 1'b1;
              end
            end else if (&act_ok) begin
              nxt_cmd = C_REF;
            end
          end else if (req_valid) begin
            if (open_q[rq_bank] && row_q[rq_bank] == rq_row) begin
              if (rw_ok[rq_bank]) begin
                nxt_cmd   = req_write ? C_WR : C_RD;
                nxt_ba    = rq_bank;
                nxt_a     = ROW_W'(rq_col);
                nxt_gap   = req_write ? GW'(half_len) : GW'(rd_gap);
                req_ready = 1'b1;
              end
            end else if (open_q[rq_bank]) begin
              if (pre_ok[rq_bank]) begin
                nxt_cmd = C_PRE; nxt_ba = rq_bank;
              end
            end else if (act_ok[rq_bank]) begin
              nxt_cmd = C_ACT; nxt_ba = rq_bank; nxt_a = rq_row;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PWR;
      cmd_q <= C_NOP;
      ba_q  <= '0;
      a_q   <= '0;
      gap_q <= GW'(T_INIT - 1);
      cl_q  <= cfg_cl;
      bl_q  <= cfg_bl;
      ilv_q <= cfg_ilv;
    end else begin
      st    <= nxt_st;
      cmd_q <= nxt_cmd;
      ba_q  <= nxt_ba;
      a_q   <= nxt_a;
      gap_q <= nxt_gap;
    end
  end

  // open-row bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int i = 0; i < NB; i++) row_q[i] <= '0;
    end else if (nxt_cmd == C_ACT) begin
      open_q[nxt_ba] <= 1'b1;
      row_q[nxt_ba]  <= nxt_a;
    end else if (nxt_cmd == C_PRE) begin
      if (nxt_a[10]) open_q <= '0;
      else           open_q[nxt_ba] <= 1'b0;
    end
  end

  ddrc_bank_timers #(
    .NB(NB), .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_RFC(T_RFC), .T_WR(T_WR)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .cmd(nxt_cmd), .bank(nxt_ba),
    .all_banks(nxt_a[10]), .burst_half(half_len),
    .act_ok(act_ok), .rw_ok(rw_ok), .pre_ok(pre_ok)
  );

  ddrc_refresh_timer #(.T_REFI(T_REFI)) u_refresh (
    .clk(clk), .rst_n(rst_n), .en(st == S_RUN),
    .clr(st == S_RUN && nxt_cmd == C_REF), .due(ref_due)
  );

  ddrc_window #(.DEPTH(4), .LW(3)) u_wr_win (
    .clk(clk), .rst_n(rst_n), .start(cmd_q == C_WR),
    .sel(2'd0), .len(half_len), .active(wd_ready)
  );

  ddrc_window #(.DEPTH(4), .LW(3)) u_rd_win (
    .clk(clk), .rst_n(rst_n), .start(cmd_q == C_RD),
    .sel(cl_int - 2'd1), .len(half_len), .active(rd_valid)
  );

  assign cmd_o     = cmd_q;
  assign ba_o      = ba_q;
  assign a_o       = a_q;
  assign init_done = (st == S_RUN);
  assign rd_half   = (cl_q == 2'd1);
  assign rd_data   = phy_rdata;
  assign phy_wdata = wd_data;
  assign phy_wmask = wd_ready ? wd_mask : '1;
endmodule

// File: rtl/ddrc_ctrl_chk.sv
module ddrc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_o,
  input logic       req_ready,
  input logic       wd_ready,
  input logic       rd_valid,
  input logic       init_done,
  input logic       rd_half
);
  p_idle_before_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);

  p_wr_window_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd3) |=> wd_ready);

  p_half_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(rd_half));

  p_ref_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd5) |=> (cmd_o == 3'd0 && !req_ready));

  p_accept_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (cmd_o == 3'd2 || cmd_o == 3'd3));

  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wd_ready));
endmodule

bind ddrc_ctrl ddrc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .req_ready(req_ready),
  .wd_ready(wd_ready), .rd_valid(rd_valid), .init_done(init_done),
  .rd_half(rd_half)
);

// File: tb/ddrc_ctrl_test.sv
module ddrc_ctrl_test;
  localparam int T_INIT = 200, T_RCD = 3, T_RP = 3, T_RAS = 6;
  localparam int T_RFC = 10, T_WR = 2, T_MRD = 2, T_REFI = 975;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  cfg_cl = 2'd0, cfg_bl = 2'd0;
  logic        cfg_ilv = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic [15:0] wd_data = '0, phy_rdata = 16'h5A5A;
  logic [1:0]  wd_mask = '0;
  logic        req_ready, wd_ready, rd_valid, init_done, rd_half;
  logic [15:0] rd_data, phy_wdata;
  logic [1:0]  phy_wmask, ba_o;
  logic [2:0]  cmd_o;
  logic [12:0] a_o;

  ddrc_ctrl #(
    .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD), .T_REFI(T_REFI)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .cfg_ilv(cfg_ilv), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .wd_ready(wd_ready),
    .wd_data(wd_data), .wd_mask(wd_mask), .rd_valid(rd_valid),
    .rd_data(rd_data), .init_done(init_done), .cmd_o(cmd_o), .ba_o(ba_o),
    .a_o(a_o), .phy_wdata(phy_wdata), .phy_wmask(phy_wmask),
    .phy_rdata(phy_rdata), .rd_half(rd_half)
  );

  always #4 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int cur_h = 1;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // command log and spacing monitor
  int ev_cmd[$], ev_cyc[$], ev_ba[$], ev_a[$];
  int last_act[4], last_pre[4], last_wend[4];
  int last_ref, last_ref_run, n_ref_run;

  task automatic clr_hist();
    for (int i = 0; i < 4; i++) begin
      last_act[i] = -1000; last_pre[i] = -1000; last_wend[i] = -1000;
    end
    last_ref = -1000; last_ref_run = -1; n_ref_run = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && cmd_o != 3'd0) begin
      ev_cmd.push_back(int'(cmd_o)); ev_cyc.push_back(cyc);
      ev_ba.push_back(int'(ba_o));   ev_a.push_back(int'(a_o));
      chk(cyc - last_ref >= T_RFC, "R10 quiet after refresh", cyc - last_ref, T_RFC);
      case (cmd_o)
        3'd1: begin
          chk(cyc - last_pre[ba_o] >= T_RP, "R9 tRP", cyc - last_pre[ba_o], T_RP);
          last_act[ba_o] = cyc;
        end
        3'd2, 3'd3: begin
          chk(cyc - last_act[ba_o] >= T_RCD, "R9 tRCD", cyc - last_act[ba_o], T_RCD);
          if (cmd_o == 3'd3) last_wend[ba_o] = cyc + cur_h;
        end
        3'd4: begin
          for (int b = 0; b < 4; b++) begin
            if (a_o[10] || ba_o == 2'(b)) begin
              chk(cyc - last_act[b] >= T_RAS, "R9 tRAS", cyc - last_act[b], T_RAS);
              chk(cyc - last_wend[b] >= T_WR, "R9 tWR", cyc - last_wend[b], T_WR);
              last_pre[b] = cyc;
            end
          end
        end
        3'd5: begin
          if (init_done) begin
            if (last_ref_run >= 0)
              chk(cyc - last_ref_run <= T_REFI + 40, "R10 refresh interval",
                  cyc - last_ref_run, T_REFI);
            last_ref_run = cyc;
            n_ref_run++;
          end
          last_ref = cyc;
        end
        default: ;
      endcase
    end
  end

  function automatic int mode_word(int cl, int bl, int ilv, int dll);
    int clc;
    clc = (cl == 0) ? 2 : (cl == 1) ? 6 : 3;
    return (dll << 8) | (clc << 4) | (ilv << 3) | (bl + 1);
  endfunction

  // reset, configure and check start-up (R1, R2, R3)
  task automatic start_up(input int cl, input int bl, input int ilv);
    int rel;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_cl = 2'(cl); cfg_bl = 2'(bl); cfg_ilv = 1'(ilv);
    cur_h = (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
    repeat (3) @(negedge clk);
    chk(cmd_o == 3'd0 && !init_done && !req_ready, "R1 reset state", int'(cmd_o), 0);
    clr_hist();
    ev_cmd.delete(); ev_cyc.delete(); ev_ba.delete(); ev_a.delete();
    rst_n = 1'b1; rel = cyc;
    repeat (5) @(negedge clk);
    chk(cmd_o == 3'd0 && !init_done && !req_ready, "R1 idle after release", int'(init_done), 0);
    while (!init_done) @(negedge clk);
    chk(ev_cmd.size() == 7, "R2 start-up count", ev_cmd.size(), 7);
    if (ev_cmd.size() == 7) begin
      chk(ev_cyc[0] - rel == T_INIT, "R2 stable wait", ev_cyc[0] - rel, T_INIT);
      chk(ev_cmd[0] == 4 && ev_a[0][10], "R2 first precharge all", ev_cmd[0], 4);
      chk(ev_cmd[1] == 6 && ev_ba[1] == 1 && ev_a[1] == 0, "R2 extended mode", ev_a[1], 0);
      chk(ev_cmd[2] == 6 && ev_ba[2] == 0, "R2 mode with dll reset", ev_cmd[2], 6);
      chk(ev_a[2] == mode_word(cl, bl, ilv, 1), "R3 mode word dll", ev_a[2], mode_word(cl, bl, ilv, 1));
      chk(ev_cmd[3] == 4 && ev_a[3][10], "R2 second precharge all", ev_cmd[3], 4);
      chk(ev_cmd[4] == 5 && ev_cmd[5] == 5, "R2 two refreshes", ev_cmd[5], 5);
      chk(ev_cmd[6] == 6 && ev_ba[6] == 0, "R2 final mode", ev_cmd[6], 6);
      chk(ev_a[6] == mode_word(cl, bl, ilv, 0), "R3 mode word", ev_a[6], mode_word(cl, bl, ilv, 0));
    end
  endtask

  // one request; exp lists the expected non-refresh command codes
  task automatic xfer(input bit wr, input int b, input int r, input int c,
                      input int n_exp, input int e0, input int e1, input int e2,
                      input string tag);
    int f[$];
    int exp_l[3];
    int cl_int;
    exp_l[0] = e0; exp_l[1] = e1; exp_l[2] = e2;
    cl_int = (cfg_cl == 2'd2) ? 3 : 2;
    @(negedge clk);
    ev_cmd.delete(); ev_cyc.delete(); ev_ba.delete(); ev_a.delete();
    req_valid = 1'b1; req_write = wr;
    req_addr = {2'(b), 13'(r), 10'(c)};
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_o == (wr ? 3'd3 : 3'd2), {"R11 column command ", tag}, int'(cmd_o), wr ? 3 : 2);
    chk(ba_o == 2'(b) && a_o[9:0] == 10'(c) && !a_o[10], "R4 column address", int'(a_o), c);
    chk(!wd_ready && !rd_valid, "R12 no window on issue", int'(wd_ready), 0);
    for (int i = 0; i < ev_cmd.size(); i++)
      if (!(ev_cmd[i] == 5 || (ev_cmd[i] == 4 && ev_a[i][10]))) f.push_back(ev_cmd[i]);
    chk(f.size() == n_exp, {"R8 R9 sequence length ", tag}, f.size(), n_exp);
    if (f.size() == n_exp)
      for (int i = 0; i < n_exp; i++)
        chk(f[i] == exp_l[i], {"R8 R9 sequence ", tag}, f[i], exp_l[i]);
    for (int j = 1; j <= cl_int + cur_h + 1; j++) begin
      @(negedge clk);
      wd_data = 16'hA500 + 16'(j); wd_mask = 2'(j);
      #1;
      if (wr) begin
        chk(wd_ready == (j <= cur_h), "R5 write window", int'(wd_ready), int'(j <= cur_h));
        if (j <= cur_h)
          chk(phy_wdata == wd_data && phy_wmask == wd_mask, "R7 data pass", int'(phy_wmask), int'(wd_mask));
        else
          chk(phy_wmask == 2'b11, "R7 mask idle", int'(phy_wmask), 3);
      end else begin
        chk(rd_valid == (j >= cl_int && j <= cl_int + cur_h - 1), "R6 read window",
            int'(rd_valid), int'(j >= cl_int && j <= cl_int + cur_h - 1));
        if (rd_valid) chk(rd_data == phy_rdata, "R6 read data", int'(rd_data), int'(phy_rdata));
      end
      chk(!(wd_ready && rd_valid), "R12 windows apart", 1, 0);
    end
    chk(rd_half == (cfg_cl == 2'd1), "R6 half flag", int'(rd_half), int'(cfg_cl == 2'd1));
  endtask

  task automatic combo_test(input int cl, input int bl);
    start_up(cl, bl, (cl + bl) % 2);
    xfer(1'b1, 1, 100, 8,  2, 1, 3, 0, "closed write");
    xfer(1'b1, 1, 100, 16, 1, 3, 0, 0, "hit write");
    xfer(1'b0, 1, 100, 8,  1, 2, 0, 0, "hit read");
    xfer(1'b0, 1, 200, 4,  3, 4, 1, 2, "miss read");
    xfer(1'b0, 2, 7,   0,  2, 1, 2, 0, "other bank");
  endtask

  task automatic refresh_test();
    int first_ref;
    ev_cmd.delete(); ev_cyc.delete(); ev_ba.delete(); ev_a.delete();
    n_ref_run = 0;
    for (int k = 0; k < 2 * T_REFI + 200 && n_ref_run < 2; k++) @(negedge clk);
    chk(n_ref_run == 2, "R10 refresh count", n_ref_run, 2);
    first_ref = -1;
    for (int i = 0; i < ev_cmd.size(); i++)
      if (ev_cmd[i] == 5 && first_ref < 0) first_ref = i;
    chk(first_ref >= 1, "R10 refresh seen", first_ref, 1);
    if (first_ref >= 1)
      chk(ev_cmd[first_ref - 1] == 4 && ev_a[first_ref - 1][10], "R10 precharge all first",
          ev_cmd[first_ref - 1], 4);
    xfer(1'b0, 2, 7, 0, 2, 1, 2, 0, "R10 rows closed by refresh");
  endtask

  initial begin
    for (int cl = 0; cl < 3; cl++)
      for (int bl = 0; bl < 3; bl++)
        combo_test(cl, bl);
    refresh_test();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule